// File: doc/BRIEF.md
# Oversampling Conversion Sequencer

This block keeps one byte of measurement configuration and runs a single oversampled conversion from a master clock. A host loads the whole byte through a simple write strobe. Setting the start bit from 0 to 1 begins a conversion. The block counts modulator steps, one for each internal clock tick, until the number set by the oversampling-ratio field is reached. It then raises an end-of-conversion flag and holds it.

The internal tick comes either from every master clock cycle or from every second one. An active-low divide bit chooses which. Both modes produce the same number of modulator steps, so the divided mode takes twice as many master cycles. The measurement-source, input-range and offset fields are decoded and brought out as static outputs for the analog section. The ratio and divide mode seen at the start of a conversion stay in force until that conversion ends, even if the register is rewritten while it runs.

Top module: `osr_conv_seq`

## Requirements
- R1: When reset is asserted, the register clears to 0x00, `eoc`, `conv_busy` and `mod_tick` go low, and `offset_en` reads 1 because bit 1 of the register is 0.
- R2: A cycle with `wr_en` high stores `wr_data` from the next clock edge onward. `meas_pressure` shows bit 4 and `range_wide` shows bit 2. A cycle without `wr_en` leaves the register unchanged.
- R3: The ratio field in bits 7:6 sets the number of `mod_tick` pulses in a conversion: code 00 gives 64, 10 gives 128, 01 gives 256 and 11 gives 512.
- R4: A write that changes bit 5 (start) from 0 to 1 begins a conversion on that edge: `conv_busy` goes high and `eoc` goes low. A write with bit 5 at 0 never starts a conversion.
- R5: When bit 3 is 1 (undivided), `mod_tick` is high on every cycle of the conversion, so the conversion lasts N master cycles for a ratio of N.
- R6: When bit 3 is 0 (divided by two), `mod_tick` is high on every second cycle and never on two cycles in a row, so the conversion lasts 2N master cycles.
- R7: `eoc` rises on the edge that consumes the last tick, at the same time as `conv_busy` falls. It stays high until a new conversion starts or bit 5 is written as 0.
- R8: Writing bit 5 as 0 stops a running conversion and clears `eoc` on that edge.
- R9: A write during a conversion updates the stored byte and the decoded outputs. The ratio and divide mode captured when the conversion started stay in use until it ends.
- R10: When bit 1 is 1, `offset_en` is 0 and `offset_hi` is 0, whatever bit 0 holds. When bit 1 is 0, `offset_en` is 1 and `offset_hi` equals bit 0.
- R11: Writing bit 5 as 1 while it is already 1 does not restart a conversion. After completion, `eoc` stays high and `conv_busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Byte written to the configuration register |
| conv_busy | output | 1 | Conversion in progress |
| eoc | output | 1 | End of conversion flag |
| mod_tick | output | 1 | Internal clock enable, one modulator step |
| meas_pressure | output | 1 | 1 selects the pressure source, 0 the temperature source |
| range_wide | output | 1 | 1 selects the wide input range |
| offset_en | output | 1 | Input offset applied |
| offset_hi | output | 1 | Higher of the two offset values selected, only when offset is applied |

## Verification
The hardest case to reach is a rewrite of the register in the middle of a conversion. The new ratio and divide bits must reach the decoded outputs but must not change the conversion's length. The bench starts the shortest undivided conversion and, a few cycles later, writes the longest ratio with division enabled while keeping the start bit at 1. It then checks that the end flag still arrives after 64 master cycles. The bench also tests a start bit written 1 over 1, and an abort in the middle of a divided conversion. For both it checks the cycle-by-cycle model against the flag and the tick output.

// File: rtl/osr_seq_pkg.sv
package osr_seq_pkg;
  localparam int CFG_W        = 8;
  localparam int OSR_MIN_LOG2 = 6;
  localparam int OSR_STEPS    = 4;
  localparam int CNT_W        = OSR_MIN_LOG2 + OSR_STEPS;

  localparam int B_OSR_HI  = 7;
  localparam int B_OSR_LO  = 6;
  localparam int B_START   = 5;
  localparam int B_SRC     = 4;
  localparam int B_UNDIV   = 3;
  localparam int B_RANGE   = 2;
  localparam int B_OFS_OFF = 1;
  localparam int B_OFS_SEL = 0;

  // code bits are reversed in weight: 00->x1, 10->x2, 01->x4, 11->x8
  function automatic logic [CNT_W-1:0] osr_len(input logic [1:0] code);
    logic [CNT_W-1:0] one;
    int               step;
    one  = CNT_W'(1);
    step = {30'd0, code[0], code[1]};
    return one << (OSR_MIN_LOG2 + step);
  endfunction
endpackage

// File: rtl/osr_cfg_reg.sv
module osr_cfg_reg
  import osr_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output logic             start_pulse,
  output logic             abort_pulse,
  output logic [1:0]       osr_next,
  output logic             undiv_next,
  output logic             src_pressure,
  output logic             rng_wide,
  output logic             ofs_en,
  output logic             ofs_hi
);
  logic [CFG_W-1:0] cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) cfg_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  always_comb begin
    start_pulse  = wr_en & wr_data[B_START] & ~cfg_q[B_START];
    abort_pulse  = wr_en & ~wr_data[B_START];
    osr_next     = wr_data[B_OSR_HI:B_OSR_LO];
    undiv_next   = wr_data[B_UNDIV];
    src_pressure = cfg_q[B_SRC];
    rng_wide     = cfg_q[B_RANGE];
    ofs_en       = ~cfg_q[B_OFS_OFF];
    ofs_hi       = ~cfg_q[B_OFS_OFF] & cfg_q[B_OFS_SEL];
  end

  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_q));
endmodule

// File: rtl/osr_tick_gen.sv
module osr_tick_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic undiv_in,
  input  logic run,
  output logic tick
);
  logic phase_q, phase_d;
  logic undiv_q, undiv_d;

  always_comb begin
    phase_d = phase_q;
    undiv_d = undiv_q;
    if (restart) begin
      phase_d = 1'b0;
      undiv_d = undiv_in;
    end else if (run) begin
      phase_d = ~phase_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      undiv_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      undiv_q <= undiv_d;
    end
  end

  assign tick = run & (undiv_q | phase_q);

  p_div_alternate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !undiv_q && !restart) |=> !tick);
  p_mode_latched_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !restart) |=> $stable(undiv_q));
endmodule

// File: rtl/osr_conv_counter.sv
module osr_conv_counter
  import osr_seq_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          abort,
  input  logic          tick,
  input  logic [CW-1:0] len_in,
  output logic          busy,
  output logic          done
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;
  logic          eoc_q, eoc_d;

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    eoc_d = eoc_q;
    if (start) begin
      cnt_d = len_in;
      act_d = 1'b1;
      eoc_d = 1'b0;
    end else if (abort) begin
      act_d = 1'b0;
      eoc_d = 1'b0;
    end else if (act_q && tick) begin
      cnt_d = cnt_q - CW'(1);
      if (cnt_q == CW'(1)) begin
        act_d = 1'b0;
        eoc_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
      eoc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
      eoc_q <= eoc_d;
    end
  end

  assign busy = act_q;
  assign done = eoc_q;

  p_cnt_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (cnt_q != '0));
  p_last_tick_eoc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && tick && cnt_q == CW'(1) && !start && !abort) |=> (eoc_q && !act_q));
endmodule

// File: rtl/osr_conv_seq.sv
module osr_conv_seq
  import osr_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output logic             conv_busy,
  output logic             eoc,
  output logic             mod_tick,
  output logic             meas_pressure,
  output logic             range_wide,
  output logic             offset_en,
  output logic             offset_hi
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_i;
  logic             start_pulse, abort_pulse;
  logic [1:0]       osr_next;
  logic             undiv_next;
  logic [CNT_W-1:0] len_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  osr_cfg_reg u_cfg (
    .clk          (clk),
    .rst_n        (rst_n_i),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .start_pulse  (start_pulse),
    .abort_pulse  (abort_pulse),
    .osr_next     (osr_next),
    .undiv_next   (undiv_next),
    .src_pressure (meas_pressure),
    .rng_wide     (range_wide),
    .ofs_en       (offset_en),
    .ofs_hi       (offset_hi)
  );

  assign len_next = osr_len(osr_next);

  osr_tick_gen u_tick (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .restart  (start_pulse),
    .undiv_in (undiv_next),
    .run      (conv_busy),
    .tick     (mod_tick)
  );

  osr_conv_counter #(.CW(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .start  (start_pulse),
    .abort  (abort_pulse),
    .tick   (mod_tick),
    .len_in (len_next),
    .busy   (conv_busy),
    .done   (eoc)
  );

  always @(posedge clk) begin
    if (!rst_n_i) begin
      p_reset_idle_r1: assert (!eoc && !conv_busy && !mod_tick);
    end
  end

  p_start_r4: assert property (@(posedge clk) disable iff (!rst_n_i)
    start_pulse |=> (conv_busy && !eoc));
  p_eoc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n_i)
    (eoc && !wr_en) |=> eoc);
  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n_i)
    (wr_en && !wr_data[B_START]) |=> (!conv_busy && !eoc));
  p_offset_gate_r10: assert property (@(posedge clk) disable iff (!rst_n_i)
    (wr_en && wr_data[B_OFS_OFF]) |=> (!offset_en && !offset_hi));
endmodule

// File: tb/osr_conv_seq_tb.sv
module osr_conv_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic conv_busy, eoc, mod_tick, meas_pressure, range_wide, offset_en, offset_hi;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  // behavioural reference state
  logic [7:0] m_cfg = 8'h00;
  bit m_active = 0, m_eoc = 0, m_undiv = 0;
  int m_elapsed = 0, m_len = 0;

  always #10 clk = ~clk;

  osr_conv_seq u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .conv_busy(conv_busy), .eoc(eoc), .mod_tick(mod_tick),
    .meas_pressure(meas_pressure), .range_wide(range_wide),
    .offset_en(offset_en), .offset_hi(offset_hi)
  );

  function automatic int ratio_of(input logic [1:0] c);
    case (c)
      2'b00: return 64;
      2'b10: return 128;
      2'b01: return 256;
      default: return 512;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cfg = 8'h00; m_active = 0; m_eoc = 0; m_elapsed = 0; m_len = 0; m_undiv = 0;
    end else if (wr_en) begin
      if (!wr_data[5]) begin
        m_active = 0; m_eoc = 0;
      end else if (!m_cfg[5]) begin
        m_active = 1; m_eoc = 0; m_elapsed = 0;
        m_undiv = wr_data[3];
        m_len = ratio_of(wr_data[7:6]) * (wr_data[3] ? 1 : 2);
      end else if (m_active) begin
        m_elapsed++;
        if (m_elapsed == m_len) begin m_active = 0; m_eoc = 1; end
      end
      m_cfg = wr_data;
    end else if (m_active) begin
      m_elapsed++;
      if (m_elapsed == m_len) begin m_active = 0; m_eoc = 1; end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !finished) begin
      check("R7", eoc, m_eoc, "eoc vs model");
      check("R4", conv_busy, m_active, "busy vs model");
      check(m_undiv ? "R5" : "R6", mod_tick,
            (m_active && (m_undiv || (m_elapsed % 2 == 1))) ? 1 : 0, "tick vs model");
      check("R2", meas_pressure, m_cfg[4], "source field");
      check("R2", range_wide, m_cfg[2], "range field");
      check("R10", offset_en, !m_cfg[1], "offset enable");
      check("R10", offset_hi, (!m_cfg[1] && m_cfg[0]) ? 1 : 0, "offset select");
    end
    if (cycles > 150000 && !finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run_conv(input logic [1:0] code, input bit undiv);
    int n, ticks;
    wr(8'h00);
    wr({code, 1'b1, 1'b1, undiv, 3'b010});
    n = 0; ticks = 0;
    while (!eoc && n < 3000) begin
      ticks += mod_tick;
      @(negedge clk);
      n++;
    end
    check("R3", ticks, ratio_of(code), "tick count");
    check(undiv ? "R5" : "R6", n, ratio_of(code) * (undiv ? 1 : 2), "conversion cycles");
  endtask

  initial begin
    idle(3);
    check("R1", eoc, 0, "eoc in reset");
    check("R1", conv_busy, 0, "busy in reset");
    check("R1", offset_en, 1, "offset_en in reset");
    @(negedge clk); rst_n = 1'b1;
    idle(4);
    check("R1", meas_pressure, 0, "source after reset");

    // R2 fields
    wr(8'b0001_0100);
    check("R2", meas_pressure, 1, "pressure bit");
    check("R2", range_wide, 1, "range bit");
    // R10 offset gating
    wr(8'b0000_0011);
    check("R10", offset_en, 0, "offset off");
    check("R10", offset_hi, 0, "select ignored");
    wr(8'b0000_0001);
    check("R10", offset_hi, 1, "select high");
    wr(8'b0000_0000);
    check("R10", offset_hi, 0, "select low");

    // R4: start 0 never converts
    wr(8'b1100_1000);
    idle(100);
    check("R4", conv_busy, 0, "no start");

    // R3 R5 R6 all codes and modes
    for (int c = 0; c < 4; c++) begin
      run_conv(2'(c), 1'b1);
      run_conv(2'(c), 1'b0);
    end

    // R7 hold and R11 no restart on 1 over 1
    idle(20);
    check("R7", eoc, 1, "eoc held");
    wr(8'b0010_1000);
    idle(5);
    check("R11", conv_busy, 0, "no restart");
    check("R11", eoc, 1, "eoc kept");

    // R8 abort in divided mode
    wr(8'h00);
    wr(8'b0110_0000);
    idle(30);
    check("R8", conv_busy, 1, "running before abort");
    wr(8'b0100_0000);
    check("R8", conv_busy, 0, "aborted");
    check("R8", eoc, 0, "eoc cleared");
    idle(600);
    check("R8", eoc, 0, "stays idle");

    // R9 mid-conversion rewrite
    wr(8'h00);
    wr(8'b0010_1000);
    begin
      int n;
      idle(9);
      wr(8'b1111_0110);
      check("R9", meas_pressure, 1, "field updated");
      n = 10;
      while (!eoc && n < 3000) begin @(negedge clk); n++; end
      check("R9", n, 64, "latched length");
    end

    idle(5);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule